// File: doc/BRIEF.md
# Keyboard Command Response Engine

This block is the command processor of an emulated keyboard. It accepts one byte at a time from the host-side receiver, each with a parity-error flag. It decides what the keyboard answers and hands the reply bytes, one per handshake, to a transmit queue. It owns the keyboard's visible state: three indicator lamps, a scanning-enabled flag, the active scan-code set and the auto-repeat rate/delay setting. It also remembers the last byte it handed out, so that the host can ask for it again.

Several commands take a second, option byte. The engine acknowledges the command and then waits for the option. A byte with bit 7 set that arrives in place of the option is taken as a new command. While a reply is still being sent, the engine refuses new host bytes by holding `rx_ready` low. It therefore never has to queue more than one reply, which is at most three bytes long. The reset command includes a self-test pause of `SELFTEST_CYCLES` clock cycles before its pass code is sent.

Top module: `kbd_cmd_engine`

## Requirements
- R1: Each host byte accepted with good parity that is a recognised command, or a valid option for a pending command, is answered first with 0xFA. The exceptions are 0xEE, 0xFE and 0xFF: 0xEE and 0xFE send no acknowledge, and 0xFF acknowledges as R9 describes. Every accepted byte gets at least one reply byte.
- R2: Command 0xED makes the next byte an indicator option. The engine sets `led[0]` (scroll), `led[1]` (num) and `led[2]` (caps) from option bits 0, 1 and 2, and acknowledges again. The lamps take their new value in the same cycle that 0xFA is offered. All lamps are off after reset.
- R3: If a byte with bit 7 set arrives while an option byte is pending, the pending command is dropped and the byte is run as a command.
- R4: Command 0xEE is answered with the single byte 0xEE.
- R5: Command 0xF2 is answered with 0xFA, 0xAB, 0x83, in that order.
- R6: Command 0xF3 takes an option byte, and `typematic` takes the option's bits 6..0. Bits 6..5 are the delay field, where value v means (v+1)×250 ms. The reset value is 0x2B: a 500 ms delay and about 10.9 repeats per second.
- R7: Command 0xF0 takes an option byte. Option 0 is answered with 0xFA followed by the current set number. Options 1 to 3 select that set. Any other option with bit 7 clear is answered with 0xFE, and the engine keeps waiting for an option. `code_set` is never 0, and it is 2 after reset.
- R8: Command 0xF4 sets `scan_en`. Command 0xF5 clears `scan_en` and restores the default `typematic`. Command 0xF6 sets `scan_en` and restores the default `typematic`. Each of the three is acknowledged.
- R9: Command 0xFF is acknowledged and returns all state to its reset values. At least `SELFTEST_CYCLES` cycles after the 0xFA is accepted, 0xAA is sent. `rx_ready` stays low until then.
- R10: Command 0xFE makes the engine send again the last byte handed to the transmit queue. This byte is 0xAA if nothing has been sent since reset.
- R11: A byte that arrives with a parity error is answered with 0xFE. It changes no state, and any pending option wait is kept.
- R12: With no option pending, a byte that is not a recognised command is answered with 0xFE and changes no state.
- R13: Commands 0xF7 to 0xFD are acknowledged and change no state. After 0xFB, 0xFC or 0xFD, the next byte with bit 7 clear is taken as a key ID and acknowledged.
- R14: While `tx_valid` is high and `tx_ready` is low, `tx_byte` holds its value. `rx_ready` is low while any reply byte is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Host byte present |
| rx_byte | input | 8 | Host byte |
| rx_perr | input | 1 | Host byte failed its parity check |
| rx_ready | output | 1 | Engine can take a host byte |
| tx_valid | output | 1 | Reply byte offered |
| tx_byte | output | 8 | Reply byte |
| tx_ready | input | 1 | Transmit queue takes the reply byte |
| led | output | 3 | Indicator lamps {caps, num, scroll} |
| scan_en | output | 1 | Scanning enabled |
| code_set | output | 2 | Active scan-code set (1..3) |
| typematic | output | 7 | Auto-repeat rate/delay setting |

## Verification
The bench targets option handling. It cancels a pending option by sending a command byte, which a design that took the byte as an option would turn into wrong lamp bits and a missing action. It sends bad parity while an option is pending; a design that dropped the wait would then answer the good option with 0xFE. The resend command is sent both after a set report and after a 0xFE. If the last-sent byte were captured at the wrong time, the retransmitted value would be stale. The bench stalls the transmit queue during the three-byte identify reply to expose a design that lets bytes slip or lets a new host byte in. It also measures the self-test gap and checks that the state returns to its reset values.

// File: rtl/kbd_cmd_pkg.sv
// Shared types and byte codes for the keyboard command response engine.
// Assumes a single 8-bit host byte stream and replies of at most three bytes.
package kbd_cmd_pkg;

    localparam logic [7:0] BYTE_ACK    = 8'hFA;
    localparam logic [7:0] BYTE_ECHO   = 8'hEE;
    localparam logic [7:0] BYTE_NAK    = 8'hFE;
    localparam logic [7:0] BYTE_PASS   = 8'hAA;
    localparam logic [7:0] BYTE_ID_LO  = 8'hAB;
    localparam logic [7:0] BYTE_ID_HI  = 8'h83;
    localparam logic [6:0] TYP_DEFAULT = 7'h2B;
    localparam logic [1:0] SET_DEFAULT = 2'd2;

    typedef enum logic [2:0] {
        WAIT_NONE,
        WAIT_LAMPS,
        WAIT_RATE,
        WAIT_SET,
        WAIT_KEYID
    } wait_e;

    typedef struct packed {
        logic [2:0] led;
        logic       scan_en;
        logic [1:0] code_set;
        logic [6:0] typ;
    } kstate_t;

    typedef struct packed {
        logic [1:0] count;
        logic       bist;
        logic [7:0] b0;
        logic [7:0] b1;
        logic [7:0] b2;
    } reply_t;

    localparam kstate_t KSTATE_RESET = '{led: 3'b000, scan_en: 1'b1,
                                         code_set: SET_DEFAULT, typ: TYP_DEFAULT};

endpackage

// File: rtl/kbd_cmd_decode.sv
// Combinational command decoder. Given one accepted host byte, its parity
// flag, the option wait in force, the keyboard state and the last byte sent,
// it returns the reply to send, the next state and the next option wait.
// Assumes the caller only commits the outputs on an accepted byte.
module kbd_cmd_decode
    import kbd_cmd_pkg::*;
(
    input  logic [7:0] in_byte,
    input  logic       in_perr,
    input  wait_e      cur_wait,
    input  kstate_t    cur_state,
    input  logic [7:0] last_sent,
    output reply_t     reply,
    output kstate_t    nxt_state,
    output wait_e      nxt_wait
);

    // Decode one host byte into a reply and the state that follows it.
    always_comb begin
        reply     = '{count: 2'd1, bist: 1'b0, b0: BYTE_ACK, b1: 8'h00, b2: 8'h00};
        nxt_state = cur_state;
        nxt_wait  = cur_wait;
        if (in_perr) begin
            reply.b0 = BYTE_NAK;
        end else if (cur_wait != WAIT_NONE && !in_byte[7]) begin
            nxt_wait = WAIT_NONE;
            case (cur_wait)
                WAIT_LAMPS: nxt_state.led = in_byte[2:0];
                WAIT_RATE:  nxt_state.typ = in_byte[6:0];
                WAIT_SET: begin
                    if (in_byte == 8'd0) begin
                        reply.count = 2'd2;
                        reply.b1    = {6'b0, cur_state.code_set};
                    end else if (in_byte <= 8'd3) begin
                        nxt_state.code_set = in_byte[1:0];
                    end else begin
                        reply.b0 = BYTE_NAK;
                        nxt_wait = cur_wait;
                    end
                end
                default: ;
            endcase
        end else begin
            nxt_wait = WAIT_NONE;
            case (in_byte)
                8'hED: nxt_wait = WAIT_LAMPS;
                8'hEE: reply.b0 = BYTE_ECHO;
                8'hF0: nxt_wait = WAIT_SET;
                8'hF2: begin
                    reply.count = 2'd3;
                    reply.b1    = BYTE_ID_LO;
                    reply.b2    = BYTE_ID_HI;
                end
                8'hF3: nxt_wait = WAIT_RATE;
                8'hF4: nxt_state.scan_en = 1'b1;
                8'hF5: begin
                    nxt_state.scan_en = 1'b0;
                    nxt_state.typ     = TYP_DEFAULT;
                end
                8'hF6: begin
                    nxt_state.scan_en = 1'b1;
                    nxt_state.typ     = TYP_DEFAULT;
                end
                8'hF7, 8'hF8, 8'hF9, 8'hFA: ;
                8'hFB, 8'hFC, 8'hFD: nxt_wait = WAIT_KEYID;
                8'hFE: reply.b0 = last_sent;
                8'hFF: begin
                    nxt_state   = KSTATE_RESET;
                    reply.count = 2'd2;
                    reply.bist  = 1'b1;
                    reply.b1    = BYTE_PASS;
                end
                default: reply.b0 = BYTE_NAK;
            endcase
        end
    end

endmodule

// File: rtl/kbd_reply_seq.sv
// Reply sequencer. Loads a reply of up to three bytes and offers them one at a
// time on a valid/ready handshake. It keeps the last byte handed over and, for
// a self-test reply, idles SELFTEST_CYCLES cycles after the first byte.
// Assumes load is only pulsed while busy is low.
module kbd_reply_seq
    import kbd_cmd_pkg::*;
#(
    parameter int SELFTEST_CYCLES = 500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  reply_t     reply,
    input  logic       tx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_byte,
    output logic       busy,
    output logic [7:0] last_sent
);

    localparam int TW = $clog2(SELFTEST_CYCLES + 1);
    localparam logic [TW-1:0] T_END = TW'(SELFTEST_CYCLES - 1);

    logic [7:0]    hold [3];
    logic [1:0]    left;
    logic [1:0]    idx;
    logic          bist;
    logic          pausing;
    logic [TW-1:0] timer;

    assign busy     = (left != 2'd0);
    assign tx_valid = busy && !pausing;
    assign tx_byte  = hold[idx];

    // Load a reply, step through its bytes and run the self-test pause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) hold[i] <= 8'h00;
            left      <= 2'd0;
            idx       <= 2'd0;
            bist      <= 1'b0;
            pausing   <= 1'b0;
            timer     <= '0;
            last_sent <= BYTE_PASS;
        end else if (load) begin
            hold[0] <= reply.b0;
            hold[1] <= reply.b1;
            hold[2] <= reply.b2;
            left    <= reply.count;
            idx     <= 2'd0;
            bist    <= reply.bist;
            pausing <= 1'b0;
            timer   <= '0;
        end else if (pausing) begin
            timer <= timer + 1'b1;
            if (timer == T_END) pausing <= 1'b0;
        end else if (tx_valid && tx_ready) begin
            last_sent <= hold[idx];
            idx       <= idx + 1'b1;
            left      <= left - 1'b1;
            if (bist && idx == 2'd0) begin
                pausing <= 1'b1;
                timer   <= '0;
            end
        end
    end

endmodule

// File: rtl/kbd_cmd_engine.sv
// Keyboard command response engine (top). It takes host bytes when no reply
// is outstanding, runs them through the decoder, and holds the keyboard state
// and the option wait. Replies leave through the sequencer.
// Assumes the host side holds rx_byte/rx_perr stable while rx_valid is high.
module kbd_cmd_engine
    import kbd_cmd_pkg::*;
#(
    parameter int SELFTEST_CYCLES = 500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       rx_perr,
    output logic       rx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_byte,
    input  logic       tx_ready,
    output logic [2:0] led,
    output logic       scan_en,
    output logic [1:0] code_set,
    output logic [6:0] typematic
);

    kstate_t    state_q, state_d;
    wait_e      wait_q, wait_d;
    reply_t     reply;
    logic       busy;
    logic       accept;
    logic [7:0] last_sent;

    assign rx_ready  = !busy;
    assign accept    = rx_valid && rx_ready;
    assign led       = state_q.led;
    assign scan_en   = state_q.scan_en;
    assign code_set  = state_q.code_set;
    assign typematic = state_q.typ;

    kbd_cmd_decode u_decode (
        .in_byte   (rx_byte),
        .in_perr   (rx_perr),
        .cur_wait  (wait_q),
        .cur_state (state_q),
        .last_sent (last_sent),
        .reply     (reply),
        .nxt_state (state_d),
        .nxt_wait  (wait_d)
    );

    kbd_reply_seq #(.SELFTEST_CYCLES(SELFTEST_CYCLES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .reply     (reply),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .tx_byte   (tx_byte),
        .busy      (busy),
        .last_sent (last_sent)
    );

    // Commit keyboard state and the option wait on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= KSTATE_RESET;
            wait_q  <= WAIT_NONE;
        end else if (accept) begin
            state_q <= state_d;
            wait_q  <= wait_d;
        end
    end

endmodule

// File: rtl/kbd_cmd_engine_chk.sv
// Checker for the keyboard command response engine, bound to the top.
// Assumes it sees the top's ports only.
module kbd_cmd_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic [7:0] rx_byte,
    input logic       rx_perr,
    input logic       rx_ready,
    input logic       tx_valid,
    input logic [7:0] tx_byte,
    input logic       tx_ready,
    input logic [2:0] led,
    input logic [1:0] code_set,
    input logic [6:0] typematic
);

    logic acc;
    assign acc = rx_valid && rx_ready;

    p_reply_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> tx_valid);

    p_lamps_move_on_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(led) |-> $past(acc));

    p_echo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !rx_perr && rx_byte == 8'hEE |=> tx_valid && tx_byte == 8'hEE);

    p_set_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        code_set != 2'd0);

    p_perr_nak_r11: assert property (@(posedge clk) disable iff (!rst_n)
        acc && rx_perr |=> tx_byte == 8'hFE && $stable(led) && $stable(typematic)
                           && $stable(code_set));

    p_tx_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte));

    p_no_take_while_busy_r14: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !rx_ready);

endmodule

bind kbd_cmd_engine kbd_cmd_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .rx_perr   (rx_perr),
    .rx_ready  (rx_ready),
    .tx_valid  (tx_valid),
    .tx_byte   (tx_byte),
    .tx_ready  (tx_ready),
    .led       (led),
    .code_set  (code_set),
    .typematic (typematic)
);

// File: tb/kbd_cmd_engine_tb.sv
module kbd_cmd_engine_tb;

    localparam int ST = 500;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_perr = 1'b0;
    logic       rx_ready;
    logic       tx_valid;
    logic [7:0] tx_byte;
    logic       tx_ready = 1'b1;
    logic [2:0] led;
    logic       scan_en;
    logic [1:0] code_set;
    logic [6:0] typematic;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    logic [7:0] cap [8];
    int cap_t [8];
    int cap_n = 0;

    always #4 clk = ~clk;

    kbd_cmd_engine #(.SELFTEST_CYCLES(ST)) u_dut (.*);

    // Record every reply byte that the queue takes at the next edge.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && tx_valid && tx_ready && cap_n < 8) begin
            cap[cap_n]   <= tx_byte;
            cap_t[cap_n] <= cyc;
            cap_n        <= cap_n + 1;
        end
    end

    // {host byte, reply count, reply bytes 0..2}, walked in order.
    localparam logic [33:0] VEC [22] = '{
        {8'hEE, 2'd1, 8'hEE, 8'h00, 8'h00},  // R4
        {8'hF2, 2'd3, 8'hFA, 8'hAB, 8'h83},  // R5
        {8'hED, 2'd1, 8'hFA, 8'h00, 8'h00},  // R2
        {8'h05, 2'd1, 8'hFA, 8'h00, 8'h00},  // R2 option
        {8'hF3, 2'd1, 8'hFA, 8'h00, 8'h00},  // R6
        {8'h7F, 2'd1, 8'hFA, 8'h00, 8'h00},  // R6 option
        {8'hF0, 2'd1, 8'hFA, 8'h00, 8'h00},  // R7
        {8'h00, 2'd2, 8'hFA, 8'h02, 8'h00},  // R7 report set 2
        {8'hF0, 2'd1, 8'hFA, 8'h00, 8'h00},  // R7
        {8'h03, 2'd1, 8'hFA, 8'h00, 8'h00},  // R7 select 3
        {8'hF0, 2'd1, 8'hFA, 8'h00, 8'h00},  // R7
        {8'h00, 2'd2, 8'hFA, 8'h03, 8'h00},  // R7 report set 3
        {8'hFE, 2'd1, 8'h03, 8'h00, 8'h00},  // R10
        {8'hED, 2'd1, 8'hFA, 8'h00, 8'h00},  // R3 start wait
        {8'hF4, 2'd1, 8'hFA, 8'h00, 8'h00},  // R3 cancel, run F4
        {8'h12, 2'd1, 8'hFE, 8'h00, 8'h00},  // R12
        {8'hFE, 2'd1, 8'hFE, 8'h00, 8'h00},  // R10 after nak
        {8'hF5, 2'd1, 8'hFA, 8'h00, 8'h00},  // R8
        {8'hF6, 2'd1, 8'hFA, 8'h00, 8'h00},  // R8
        {8'hFB, 2'd1, 8'hFA, 8'h00, 8'h00},  // R13
        {8'h1C, 2'd1, 8'hFA, 8'h00, 8'h00},  // R13 key id
        {8'hF7, 2'd1, 8'hFA, 8'h00, 8'h00}   // R13
    };

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input logic pe);
        cap_n = 0;
        @(negedge clk);
        while (!rx_ready) @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        rx_perr  = pe;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_perr  = 1'b0;
        while (!rx_ready) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R2, R6, R7, R8).
        check(led == 3'b000, "R2 reset lamps", led, 0);
        check(typematic == 7'h2B, "R6 reset rate", typematic, 'h2B);
        check(code_set == 2'd2, "R7 reset set", code_set, 2);
        check(scan_en == 1'b1, "R8 reset scan", scan_en, 1);
        send(8'hFE, 1'b0);
        check(cap_n == 1 && cap[0] == 8'hAA, "R10 first resend", cap[0], 'hAA);

        for (int i = 0; i < 22; i++) begin
            send(VEC[i][33:26], 1'b0);
            check(cap_n == int'(VEC[i][25:24]), "R1 reply count", cap_n, VEC[i][25:24]);
            check(cap[0] == VEC[i][23:16], "R1 reply byte0", cap[0], VEC[i][23:16]);
            if (VEC[i][25:24] > 1)
                check(cap[1] == VEC[i][15:8], "R5 R7 reply byte1", cap[1], VEC[i][15:8]);
            if (VEC[i][25:24] > 2)
                check(cap[2] == VEC[i][7:0], "R5 reply byte2", cap[2], VEC[i][7:0]);
        end
        check(led == 3'b101, "R2 lamps", led, 5);
        check(code_set == 2'd3, "R7 set", code_set, 3);
        check(scan_en == 1'b1, "R8 scan after F6", scan_en, 1);
        check(typematic == 7'h2B, "R8 rate default", typematic, 'h2B);

        // R6 rate option.
        send(8'hF3, 1'b0);
        send(8'h5A, 1'b0);
        check(typematic == 7'h5A, "R6 rate", typematic, 'h5A);

        // R8 disable.
        send(8'hF5, 1'b0);
        check(scan_en == 1'b0, "R8 F5 scan off", scan_en, 0);

        // R11 bad parity keeps the wait and the state.
        send(8'hED, 1'b0);
        send(8'h07, 1'b1);
        check(cap[0] == 8'hFE, "R11 nak", cap[0], 'hFE);
        check(led == 3'b101, "R11 lamps kept", led, 5);
        send(8'h06, 1'b0);
        check(cap[0] == 8'hFA && led == 3'b110, "R11 wait kept", led, 6);

        // R7 out-of-range set option keeps waiting.
        send(8'hF0, 1'b0);
        send(8'h04, 1'b0);
        check(cap[0] == 8'hFE && code_set == 2'd3, "R7 bad option", cap[0], 'hFE);
        send(8'h01, 1'b0);
        check(cap[0] == 8'hFA && code_set == 2'd1, "R7 select 1", code_set, 1);

        // R12 unknown command leaves state alone.
        send(8'h80, 1'b0);
        check(cap[0] == 8'hFE && led == 3'b110 && code_set == 2'd1, "R12 unknown", cap[0], 'hFE);

        // R14 backpressure on the identify reply.
        @(negedge clk);
        tx_ready = 1'b0;
        rx_valid = 1'b1;
        rx_byte  = 8'hF2;
        cap_n    = 0;
        @(negedge clk);
        rx_valid = 1'b0;
        repeat (4) @(negedge clk);
        check(tx_valid && tx_byte == 8'hFA && !rx_ready, "R14 hold", tx_byte, 'hFA);
        tx_ready = 1'b1;
        while (!rx_ready) @(negedge clk);
        @(negedge clk);
        check(cap_n == 3 && cap[1] == 8'hAB && cap[2] == 8'h83, "R14 drain", cap_n, 3);

        // R9 self test.
        send(8'hFF, 1'b0);
        check(cap_n == 2 && cap[0] == 8'hFA && cap[1] == 8'hAA, "R9 replies", cap[1], 'hAA);
        check(cap_t[1] - cap_t[0] >= ST && cap_t[1] - cap_t[0] <= ST + 2, "R9 gap",
              cap_t[1] - cap_t[0], ST);
        check(led == 3'b000 && code_set == 2'd2 && scan_en && typematic == 7'h2B,
              "R9 state reset", {led, code_set}, 'h02);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule